// File: doc/BRIEF.md
# Bloom-filter prefetch deduplicator

This block sits between a prefetch address generator and the prefetch issue queue. It takes one candidate address per cycle and decides whether a request for the same cache line was probably issued recently. Each candidate's line address is hashed twice into a 4096-bit array. When both selected bits are already set, the candidate is consumed and silently dropped. Otherwise it is placed in a one-entry issue register and offered to the queue.

Bits are set only at the clock edge where the queue takes the request. An insertion made in the same cycle as a probe is forwarded to that probe. A counter of insertions clears the whole array once the count passes a fixed limit, so old entries age out without any per-entry deletion.

Top module: `bloom_dedup`

## Requirements
- R1: After reset `issue_valid_o` is low, `cand_ready_o` is high and every filter bit is clear.
- R2: The probe key is the line address `cand_addr_i[ADDR_W-1:6]`, so the low 6 bits are ignored. Hash H0 bit j is the XOR of all line bits b with b mod 12 = j. Hash H1 bit j is the XOR of all line bits b with (b mod 12 + 5*(b div 12)) mod 12 = j. A candidate hits only when the array bits at both H0 and H1 are set.
- R3: A candidate taken while it hits is consumed (`cand_ready_o` high) and never appears on the issue port. `issue_valid_o` is low in the next cycle unless an earlier entry is still held.
- R4: A candidate taken while it misses is presented on `issue_valid_o`/`issue_addr_o`, with its full address unchanged, in the cycle after it was taken.
- R5: `cand_ready_o` equals `!issue_valid_o || issue_ready_i`. A presented issue request keeps its valid and address stable until `issue_ready_i` is high.
- R6: A request's two bits are set, and the insertion counter advances, only at the edge where `issue_valid_o && issue_ready_i`. A stalled request changes neither.
- R7: A candidate probed in the same cycle that a request for the same line is accepted by the queue is a hit.
- R8: On the 513th insertion since reset or since the last clear, the counter returns to zero and the next cycle is a flush cycle. In a flush cycle a probe sees only the bits written by an insertion in that same cycle. At the end of the flush cycle the array is cleared, keeping only that same-cycle insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Candidate address valid |
| cand_addr_i | input | ADDR_W | Candidate prefetch address |
| cand_ready_o | output | 1 | Candidate taken this cycle |
| issue_valid_o | output | 1 | Issue request valid |
| issue_addr_o | output | ADDR_W | Issue request address |
| issue_ready_i | input | 1 | Issue queue accepts the request |

## Verification
A bit wrongly set in the array appears as a dropped candidate: the issue port stays empty in the cycle after the take. A bit wrongly clear appears as a duplicate issue in that same next cycle. An insertion counter that is off by even one moves the flush cycle. A line that was inserted earlier and is probed in the expected flush cycle then shows up as a dropped request instead of an issued one, one cycle after the probe. The hold and ready relation is visible in the same cycle as the stall.

// File: rtl/dedup_pkg.sv
package dedup_pkg;
  localparam int unsigned NUM_HASH = 2;
  localparam int unsigned ROT_STEP = 5;  // per-chunk rotation step of hash k>0

  function automatic int unsigned hash_pos(input int unsigned b, input int unsigned k,
                                           input int unsigned idx_w);
    return (b % idx_w + k * ROT_STEP * (b / idx_w)) % idx_w;
  endfunction
endpackage

// File: rtl/dedup_hash.sv
module dedup_hash #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned K      = 0
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int unsigned b = 0; b < LINE_W; b++)
      idx_o[dedup_pkg::hash_pos(b, K, IDX_W)] = idx_o[dedup_pkg::hash_pos(b, K, IDX_W)] ^ line_i[b];
  end
endmodule

// File: rtl/dedup_hash_bank.sv
module dedup_hash_bank #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned NH     = dedup_pkg::NUM_HASH
) (
  input  logic [LINE_W-1:0]         line_i,
  output logic [NH-1:0][IDX_W-1:0]  idx_o
);
  for (genvar k = 0; k < NH; k++) begin : g_hash
    dedup_hash #(.LINE_W(LINE_W), .IDX_W(IDX_W), .K(k)) i_hash (
      .line_i(line_i),
      .idx_o (idx_o[k])
    );
  end
endmodule

// File: rtl/dedup_bitmap.sv
module dedup_bitmap #(
  parameter int unsigned FILT_BITS = 4096,
  parameter int unsigned NH        = dedup_pkg::NUM_HASH,
  localparam int unsigned IDX_W    = $clog2(FILT_BITS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     ins_i,
  input  logic [NH-1:0][IDX_W-1:0] ins_idx_i,
  input  logic [NH-1:0][IDX_W-1:0] probe_idx_i,
  output logic                     hit_o
);
  logic [FILT_BITS-1:0] bits_q, bits_d;
  logic [NH-1:0]        set_k;

  // flush clears first, then the same-cycle insertion lands
  always_comb begin
    bits_d = flush_i ? '0 : bits_q;
    if (ins_i)
      for (int unsigned k = 0; k < NH; k++) bits_d[ins_idx_i[k]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;

  // write-before-read forwarding of the insertion in flight
  always_comb begin
    for (int unsigned k = 0; k < NH; k++) begin
      set_k[k] = bits_q[probe_idx_i[k]] && !flush_i;
      for (int unsigned j = 0; j < NH; j++)
        if (ins_i && ins_idx_i[j] == probe_idx_i[k]) set_k[k] = 1'b1;
    end
  end
  assign hit_o = &set_k;

  assert_flush_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> $countones(bits_q) <= NH);
  assert_ins_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> bits_q[$past(ins_idx_i[0])] && bits_q[$past(ins_idx_i[NH-1])]);
  assert_no_ins_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_i && !flush_i |=> $stable(bits_q));
endmodule

// File: rtl/dedup_flush_ctr.sv
module dedup_flush_ctr #(
  parameter int unsigned LIMIT = 512,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ins_i,
  output logic flush_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = ins_i && (cnt_q == CNT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= wrap;
      if (wrap)       cnt_q <= '0;
      else if (ins_i) cnt_q <= cnt_q + 1'b1;
    end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LIMIT));
  assert_flush_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(ins_i) && cnt_q == '0);
  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_i |=> $stable(cnt_q));
endmodule

// File: rtl/dedup_out_stage.sv
module dedup_out_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o));
endmodule

// File: rtl/bloom_dedup.sv
module bloom_dedup #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_OFS    = 6,
  parameter int unsigned FILT_BITS   = 4096,
  parameter int unsigned FLUSH_LIMIT = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ADDR_W-1:0] cand_addr_i,
  output logic              cand_ready_o,
  output logic              issue_valid_o,
  output logic [ADDR_W-1:0] issue_addr_o,
  input  logic              issue_ready_i
);
  localparam int unsigned NH     = dedup_pkg::NUM_HASH;
  localparam int unsigned IDX_W  = $clog2(FILT_BITS);
  localparam int unsigned LINE_W = ADDR_W - LINE_OFS;

  logic [NH-1:0][IDX_W-1:0] probe_idx, ins_idx;
  logic take, hit, ins, flush;

  assign cand_ready_o = !issue_valid_o || issue_ready_i;
  assign take         = cand_valid_i && cand_ready_o;
  assign ins          = issue_valid_o && issue_ready_i;

  dedup_hash_bank #(.LINE_W(LINE_W), .IDX_W(IDX_W), .NH(NH)) i_probe_hash (
    .line_i(cand_addr_i[ADDR_W-1:LINE_OFS]),
    .idx_o (probe_idx)
  );

  dedup_hash_bank #(.LINE_W(LINE_W), .IDX_W(IDX_W), .NH(NH)) i_ins_hash (
    .line_i(issue_addr_o[ADDR_W-1:LINE_OFS]),
    .idx_o (ins_idx)
  );

  dedup_bitmap #(.FILT_BITS(FILT_BITS), .NH(NH)) i_bitmap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .ins_i      (ins),
    .ins_idx_i  (ins_idx),
    .probe_idx_i(probe_idx),
    .hit_o      (hit)
  );

  dedup_flush_ctr #(.LIMIT(FLUSH_LIMIT)) i_flush_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ins_i  (ins),
    .flush_o(flush)
  );

  dedup_out_stage #(.ADDR_W(ADDR_W)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take && !hit),
    .addr_i (cand_addr_i),
    .ready_i(issue_ready_i),
    .valid_o(issue_valid_o),
    .addr_o (issue_addr_o)
  );

  assert_drop_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && hit |=> !issue_valid_o);
  assert_issue_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !hit |=> issue_valid_o && issue_addr_o == $past(cand_addr_i));
  assert_fwd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && ins && cand_addr_i[ADDR_W-1:LINE_OFS] == issue_addr_o[ADDR_W-1:LINE_OFS]
    |=> !issue_valid_o);
endmodule

// File: tb/test_bloom_dedup.sv
module test_bloom_dedup;
  localparam int unsigned LIM = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid_i = 1'b0;
  logic [31:0] cand_addr_i = '0;
  logic        cand_ready_o;
  logic        issue_valid_o;
  logic [31:0] issue_addr_o;
  logic        issue_ready_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [4095:0] mbits = '0;
  int            mcnt = 0;
  bit            mflush = 0, mv = 0;
  logic [31:0]   maddr = '0;
  string         ptag = "";

  always #2.5 clk = ~clk;

  bloom_dedup i_bloom_dedup (
    .clk_i(clk), .rst_ni(rst_n), .cand_valid_i(cand_valid_i), .cand_addr_i(cand_addr_i),
    .cand_ready_o(cand_ready_o), .issue_valid_o(issue_valid_o), .issue_addr_o(issue_addr_o),
    .issue_ready_i(issue_ready_i));

  function automatic logic [11:0] bh(input logic [25:0] line, input int k);
    logic [11:0] h = '0;
    for (int b = 0; b < 26; b++) h[(b % 12 + 5 * k * (b / 12)) % 12] ^= line[b];
    return h;
  endfunction

  function automatic logic [31:0] la(input logic [25:0] line, input logic [5:0] ofs);
    return {line, ofs};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cv, input logic [31:0] ca, input bit ir, input string tg);
    bit take, hit, hit_arr, nf_hit, ins, fl_n;
    logic [11:0] p0, p1, i0, i1;
    @(negedge clk);
    cand_valid_i = cv; cand_addr_i = ca; issue_ready_i = ir;
    #1;
    chk(cand_ready_o === (!mv || ir), "R5 ready", {63'd0, cand_ready_o}, {63'd0, (!mv || ir)});
    chk(issue_valid_o === mv && (!mv || issue_addr_o === maddr), (ptag != "") ? ptag : "R5 hold",
        {31'd0, issue_valid_o, issue_addr_o}, {31'd0, mv, maddr});
    ins  = mv && ir;
    take = cv && (!mv || ir);
    i0 = bh(maddr[31:6], 0); i1 = bh(maddr[31:6], 1);
    p0 = bh(ca[31:6], 0);    p1 = bh(ca[31:6], 1);
    nf_hit  = mbits[p0] && mbits[p1];
    hit_arr = nf_hit && !mflush;
    hit = ((mbits[p0] && !mflush) || (ins && (i0 == p0 || i1 == p0))) &&
          ((mbits[p1] && !mflush) || (ins && (i0 == p1 || i1 == p1)));
    if (!take)                 ptag = "";
    else if (tg != "")         ptag = tg;
    else if (hit && !hit_arr)  ptag = "R7 fwd";
    else if (hit)              ptag = "R3 drop";
    else if (mflush && nf_hit) ptag = "R8 flush";
    else                       ptag = "R4 issue";
    if (mflush) mbits = '0;
    fl_n = 0;
    if (ins) begin
      mbits[i0] = 1'b1; mbits[i1] = 1'b1;
      if (mcnt == LIM) begin mcnt = 0; fl_n = 1; end
      else mcnt++;
    end
    mflush = fl_n;
    if (take && !hit) begin mv = 1; maddr = ca; end
    else if (ir) mv = 0;
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [25:0] ln;
    seed = $urandom(32'h5EED_0042);
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cand_ready_o === 1'b1 && issue_valid_o === 1'b0, "R1 reset",
        {62'd0, cand_ready_o, issue_valid_o}, 64'h2);

    // R2: line key, two hashes, shared bits
    step(1, la(26'h1, 6'h00), 1, "R4 first");
    step(0, '0, 1, "");
    step(1, la(26'h1, 6'h15), 1, "R2 low bits ignored"); // same line, hit
    step(1, la(26'h1000, 6'h00), 1, "R2 one hash set");   // H0 set, H1 clear
    step(0, '0, 1, "");
    step(1, la(26'h20, 6'h3f), 1, "R2 both set by others"); // false positive
    step(1, la(26'h20000, 6'h00), 1, "R2 H1 differs");
    step(0, '0, 1, "");

    // R5/R7: stall then forward accepted insertion into probe
    step(1, la(26'h2AB_CDE, 6'h04), 0, "R4 load");
    step(1, la(26'h2AB_CDE, 6'h08), 0, "");
    step(1, la(26'h2AB_CDE, 6'h08), 0, "");
    step(1, la(26'h2AB_CDE, 6'h08), 1, "R7 same-cycle insert");
    step(0, '0, 1, "");

    // R6/R8: fill with random stalls until the 513th insertion is pending
    while (!(mcnt == LIM && mv)) begin
      ln = 26'($urandom);
      step(1, la(ln, 6'($urandom)), ($urandom % 4) != 0, "");
    end
    step(0, '0, 1, "");                              // 513th insertion
    step(1, la(26'h1, 6'h01), 1, "R6 R8 flush probe"); // earlier line now misses
    step(1, la(26'h1000, 6'h02), 1, "R8 after clear");
    step(0, '0, 1, "");
    step(1, la(26'h1, 6'h03), 1, "R3 reinserted hit");
    step(0, '0, 1, "");

    // random mix: reuse pool lines to make hits, fresh lines to make misses
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 2) ln = 26'($urandom % 48);
      else ln = 26'($urandom);
      step(($urandom % 5) != 0, la(ln, 6'($urandom)), ($urandom % 4) != 0, "");
    end
    step(0, '0, 1, "");
    step(0, '0, 1, "");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule